// File: doc/BRIEF.md
# Splittable Down-Counter Timer

This block is a timer peripheral with a 32-bit register port. It behaves as two independent 32-bit down-counters, called half A and half B, or as one 64-bit down-counter built from the same two words. A mode register selects between the two. Each counter is loaded through a load register, counts down by one per clock while its run bit is set, and reloads itself when it reaches zero.

Each time a counter reaches zero it sets a sticky raw status flag. Software clears the flag by writing 1 to it. A masked view of each flag, gated by an interrupt-enable bit, drives a dedicated interrupt output. A write that actually changes the mode bit wipes every register, counter and flag back to its power-up value, so the timer always starts clean in its new shape.

The register port is a plain single-cycle write strobe with a combinational read. Word addresses are: 0 low load, 1 high load, 2 low count, 3 high count, 4 half-A control, 5 half-B control, 6 wide control, 7 half-A raw, 8 half-B raw, 9 wide raw, 10 half-A masked, 11 half-B masked, 12 wide masked, 13 mode.

Top module: `split_timer`

## Requirements
- R1: With the mode bit (address 13, bit 0) at 0, the low word is half A and the high word is half B, and each runs on its own. A write to a load register (address 0 or 1) also places the value in that half's counter. While the half's run bit (control bit 0) is 1, its counter drops by one per clock. In the clock after the count is 0, the counter reloads and that half's raw flag (bit 0 of address 7 or 8) is set.
- R2: With the mode bit at 1 the counter is {high, low}, run by the wide control (address 6). The high word decrements only in a clock where the low word wraps from 0. In the clock after both words are 0, both words reload from the load registers and the wide raw flag (address 9, bit 0) is set.
- R3: A raw flag, once set, stays set, even when zero is reached again.
- R4: Writing a word with bit 0 = 1 to a raw flag address clears that flag. Writing a word with bit 0 = 0 leaves it unchanged.
- R5: When a zero event and a clearing write hit the same flag in the same clock, the flag ends up set.
- R6: Each masked flag (addresses 10 to 12) reads as raw AND the interrupt enable (control bit 1), and ignores writes. The matching interrupt output (irq_a, irq_b, irq_wide) always equals the masked flag.
- R7: A write to the mode address whose bit 0 differs from the current mode stores the new mode and returns every other register, both counters and all flags to 0. A write with the same bit 0 changes nothing.
- R8: A counter holds its value while its run bit is 0, and also while its counting shape is not the selected mode.
- R9: After reset every address reads 0 and all interrupt outputs are 0. Unused bits of the control, flag and mode words read 0.
- R10: Count and masked addresses ignore writes. Control words keep only bits 1:0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_a | output | 1 | Half-A interrupt (masked flag) |
| irq_b | output | 1 | Half-B interrupt (masked flag) |
| irq_wide | output | 1 | 64-bit interrupt (masked flag) |

## Verification
The two functions that can collide are a counter reaching zero, which sets its raw flag, and a software write of 1 that clears the same flag. Half B is loaded with a short period and started. The bench counts clocks from the start so that the clearing write lands exactly on the clock where the counter reloads. It then judges that the flag still reads 1. A second clearing write, placed on a clock with no zero event, must read back 0, which shows the clear itself works.

// File: rtl/split_timer_pkg.sv
// Shared definitions for the splittable timer: word addresses and the
// control field layout. Assumes a 4-bit word address.
package split_timer_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_LOAD_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_LOAD_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTL_A   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CTL_B   = 4'd5;
    localparam logic [ADDR_W-1:0] A_CTL_W   = 4'd6;
    localparam logic [ADDR_W-1:0] A_RAW_A   = 4'd7;
    localparam logic [ADDR_W-1:0] A_RAW_B   = 4'd8;
    localparam logic [ADDR_W-1:0] A_RAW_W   = 4'd9;
    localparam logic [ADDR_W-1:0] A_MSK_A   = 4'd10;
    localparam logic [ADDR_W-1:0] A_MSK_B   = 4'd11;
    localparam logic [ADDR_W-1:0] A_MSK_W   = 4'd12;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'd13;

    // Control word: bit 1 interrupt enable, bit 0 run.
    typedef struct packed {
        logic ie;
        logic run;
    } ctl_t;

    // Flag index order shared by status arrays.
    localparam int F_A = 0;
    localparam int F_B = 1;
    localparam int F_W = 2;
    localparam int N_FLAGS = 3;
endpackage

// File: rtl/split_timer_word.sv
// One 32-bit (parameterised) counter word. Priority: wipe, direct load,
// reload, decrement. Assumes the caller makes dec and reload exclusive.
module split_timer_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic         ld_we,
    input  logic [W-1:0] ld_data,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)  cnt <= '0;
        else if (ld_we)      cnt <= ld_data;
        else if (reload)     cnt <= reload_val;
        else if (dec)        cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/split_timer_flag.sv
// Sticky raw status flag with write-1 clear and an enable-gated output.
// A set event beats a clear in the same cycle; wipe beats both.
module split_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic raw,
    output logic irq
);
    // Raw flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) raw <= 1'b0;
        else if (set)       raw <= 1'b1;
        else if (clr)       raw <= 1'b0;
    end

    // Masked view drives the interrupt directly.
    assign irq = raw & ie;
endmodule

// File: rtl/split_timer_regs.sv
// Register file and address decode: load words, controls and mode, the
// mode-change wipe, write-side strobes and the read mux. Assumes a
// single-cycle write strobe and a combinational read.
module split_timer_regs
    import split_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cnt_lo,
    input  logic [W-1:0]      cnt_hi,
    input  logic [N_FLAGS-1:0] raw,
    input  logic [N_FLAGS-1:0] msk,
    output logic [W-1:0]      load_lo,
    output logic [W-1:0]      load_hi,
    output ctl_t              ctl [N_FLAGS],
    output logic              mode,
    output logic              wipe,
    output logic              ld_we_lo,
    output logic              ld_we_hi,
    output logic [N_FLAGS-1:0] clr,
    output logic [W-1:0]      rdata
);
    localparam int PAD_1 = W - 1;
    localparam int PAD_2 = W - 2;

    logic wr_mode;

    // Write-side decode.
    assign wr_mode  = wr_en && (addr == A_MODE);
    assign wipe     = wr_mode && (wdata[0] != mode);
    assign ld_we_lo = wr_en && (addr == A_LOAD_LO);
    assign ld_we_hi = wr_en && (addr == A_LOAD_HI);
    assign clr[F_A] = wr_en && (addr == A_RAW_A) && wdata[0];
    assign clr[F_B] = wr_en && (addr == A_RAW_B) && wdata[0];
    assign clr[F_W] = wr_en && (addr == A_RAW_W) && wdata[0];

    // Mode bit: survives the wipe it causes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= 1'b0;
        else if (wr_mode) mode <= wdata[0];
    end

    // Load words.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            load_lo <= '0;
            load_hi <= '0;
        end else begin
            if (ld_we_lo) load_lo <= wdata;
            if (ld_we_hi) load_hi <= wdata;
        end
    end

    // Control words, one per flag, at consecutive addresses.
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                ctl[i] <= '0;
            else if (wr_en && (addr == A_CTL_A + ADDR_W'(i)))
                ctl[i] <= ctl_t'(wdata[1:0]);
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_LOAD_LO: rdata = load_lo;
            A_LOAD_HI: rdata = load_hi;
            A_CNT_LO:  rdata = cnt_lo;
            A_CNT_HI:  rdata = cnt_hi;
            A_CTL_A:   rdata = {{PAD_2{1'b0}}, ctl[F_A]};
            A_CTL_B:   rdata = {{PAD_2{1'b0}}, ctl[F_B]};
            A_CTL_W:   rdata = {{PAD_2{1'b0}}, ctl[F_W]};
            A_RAW_A:   rdata = {{PAD_1{1'b0}}, raw[F_A]};
            A_RAW_B:   rdata = {{PAD_1{1'b0}}, raw[F_B]};
            A_RAW_W:   rdata = {{PAD_1{1'b0}}, raw[F_W]};
            A_MSK_A:   rdata = {{PAD_1{1'b0}}, msk[F_A]};
            A_MSK_B:   rdata = {{PAD_1{1'b0}}, msk[F_B]};
            A_MSK_W:   rdata = {{PAD_1{1'b0}}, msk[F_W]};
            A_MODE:    rdata = {{PAD_1{1'b0}}, mode};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/split_timer.sv
// Top of the splittable timer. Mode 0: two independent down-counters on
// the low and high words. Mode 1: one down-counter across {high, low}.
// Assumes synchronous active-low reset and a single clock.
module split_timer
    import split_timer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_wide
);
    localparam int NW = 2;

    logic [WORD_W-1:0]  load_lo, load_hi;
    ctl_t               ctl [N_FLAGS];
    logic               mode, wipe, ld_we_lo, ld_we_hi;
    logic [N_FLAGS-1:0] clr, set, raw, msk;

    logic [WORD_W-1:0]  cnt    [NW];
    logic [WORD_W-1:0]  ld_val [NW];
    logic [NW-1:0]      ld_we, reload, dec, is_zero;
    logic               zero_w;

    split_timer_regs #(.W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_lo(cnt[0]), .cnt_hi(cnt[1]), .raw(raw), .msk(msk),
        .load_lo(load_lo), .load_hi(load_hi), .ctl(ctl), .mode(mode),
        .wipe(wipe), .ld_we_lo(ld_we_lo), .ld_we_hi(ld_we_hi), .clr(clr),
        .rdata(rdata)
    );

    assign ld_we     = {ld_we_hi, ld_we_lo};
    assign ld_val[0] = load_lo;
    assign ld_val[1] = load_hi;

    // Zero detection per word and for the fused count.
    for (genvar i = 0; i < NW; i++) begin : g_zero
        assign is_zero[i] = (cnt[i] == '0);
    end
    assign zero_w = &is_zero;

    // Counter steering for the selected shape.
    always_comb begin
        if (mode) begin
            reload = {NW{ctl[F_W].run && zero_w}};
            dec[0] = ctl[F_W].run && !zero_w;
            dec[1] = ctl[F_W].run && !zero_w && is_zero[0];
        end else begin
            reload[0] = ctl[F_A].run && is_zero[0];
            reload[1] = ctl[F_B].run && is_zero[1];
            dec[0]    = ctl[F_A].run && !is_zero[0];
            dec[1]    = ctl[F_B].run && !is_zero[1];
        end
    end

    // Zero events feed the status flags.
    assign set[F_A] = !mode && reload[0];
    assign set[F_B] = !mode && reload[1];
    assign set[F_W] =  mode && reload[0];

    for (genvar i = 0; i < NW; i++) begin : g_word
        split_timer_word #(.W(WORD_W)) u_word (
            .clk(clk), .rst_n(rst_n), .wipe(wipe), .ld_we(ld_we[i]),
            .ld_data(wdata), .reload(reload[i]), .reload_val(ld_val[i]),
            .dec(dec[i]), .cnt(cnt[i])
        );
    end

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        split_timer_flag u_flag (
            .clk(clk), .rst_n(rst_n), .wipe(wipe), .set(set[i]),
            .clr(clr[i]), .ie(ctl[i].ie), .raw(raw[i]), .irq(msk[i])
        );
    end

    assign irq_a    = msk[F_A];
    assign irq_b    = msk[F_B];
    assign irq_wide = msk[F_W];
endmodule

// File: rtl/split_timer_chk.sv
// Property checker for the splittable timer, bound into the top.
module split_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode,
    input logic         wipe,
    input logic [2:0]   set,
    input logic [2:0]   clr,
    input logic [2:0]   raw,
    input logic [W-1:0] load_lo,
    input logic [W-1:0] cnt_lo
);
    for (genvar i = 0; i < 3; i++) begin : g_flag
        // R5: a zero event always lands in the flag.
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !wipe) |=> raw[i]);
        // R3: a set flag stays set until cleared or wiped.
        assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (raw[i] && !clr[i] && !wipe) |=> raw[i]);
        // R4: a clearing write with no competing event clears.
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i] && !wipe) |=> !raw[i]);
    end

    // R1: the wide flag never shows while split into halves.
    assert_wide_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !raw[2]);

    // R7: a mode change leaves load, count and flags at zero.
    assert_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (load_lo == '0) && (cnt_lo == '0) && (raw == 3'b000));
endmodule

bind split_timer split_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wipe(wipe), .set(set),
    .clr(clr), .raw(raw), .load_lo(load_lo), .cnt_lo(cnt[0])
);

// File: tb/split_timer_test.sv
`timescale 1ns/1ps
module split_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_a, irq_b, irq_wide;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    split_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b), .irq_wide(irq_wide)
    );

    // Addresses, as listed in the requirements.
    localparam logic [3:0] LLO = 0, LHI = 1, CLO = 2, CHI = 3, CTA = 4,
        CTB = 5, CTW = 6, RWA = 7, RWB = 8, RWW = 9, MKA = 10, MKB = 11,
        MKW = 12, MOD = 13;

    // Vector: {is_read, addr, data/expected, requirement number}.
    localparam int NV = 16;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, LLO, 32'h1234_5678, 4'd1},
        {1'b1, LLO, 32'h1234_5678, 4'd10},
        {1'b1, CLO, 32'h1234_5678, 4'd1},
        {1'b0, LHI, 32'hCAFE_F00D, 4'd1},
        {1'b1, CHI, 32'hCAFE_F00D, 4'd1},
        {1'b0, CLO, 32'h0000_0005, 4'd10},   // R10 count ignores writes
        {1'b1, CLO, 32'h1234_5678, 4'd10},
        {1'b0, CTA, 32'hFFFF_FFFE, 4'd10},
        {1'b1, CTA, 32'h0000_0002, 4'd10},
        {1'b0, CTA, 32'h0000_0000, 4'd10},
        {1'b0, MOD, 32'hFFFF_FFFE, 4'd7},    // R7 same mode bit, no wipe
        {1'b1, LHI, 32'hCAFE_F00D, 4'd7},
        {1'b1, MOD, 32'h0000_0000, 4'd7},
        {1'b1, 4'd15, 32'h0000_0000, 4'd10},
        {1'b0, MKA, 32'h0000_0001, 4'd6},    // R6 masked ignores writes
        {1'b1, MKA, 32'h0000_0000, 4'd6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset values everywhere.
        for (int a = 0; a < 14; a++) rd(4'(a), 32'h0, "R9 reset read");
        check("R9 irq reset", {29'h0, irq_a, irq_b, irq_wide}, 32'h0);

        // Table of register decode vectors.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) rd(VEC[i][39:36], VEC[i][35:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
            else            wr(VEC[i][39:36], VEC[i][35:4]);
        end
        check("R6 irq_a with raw 0", {31'h0, irq_a}, 32'h0);

        // R1: half A counts and reloads, period load+1.
        wr(LLO, 3);
        wr(CTA, 1);
        wait_cyc(2);
        rd(CLO, 1, "R1 half A count");
        rd(RWA, 0, "R1 half A raw before zero");
        wait_cyc(2);
        rd(RWA, 1, "R1 half A raw after zero");
        rd(CLO, 3, "R1 half A reload");
        wr(CTA, 0);
        wait_cyc(3);
        rd(CLO, 1, "R8 half A holds when stopped");
        rd(CHI, 32'hCAFE_F00D, "R1 half B untouched");

        // R4 / R6 on the stopped half A.
        wr(RWA, 0);
        rd(RWA, 1, "R4 write 0 keeps flag");
        wr(RWA, 32'hFFFF_FFFE);
        rd(RWA, 1, "R4 bit0 clear keeps flag");
        wr(CTA, 2);
        rd(MKA, 1, "R6 masked set");
        check("R6 irq_a", {31'h0, irq_a}, 32'h1);
        wr(MKA, 0);
        rd(MKA, 1, "R6 masked ignores write");
        wr(RWA, 1);
        rd(RWA, 0, "R4 write 1 clears");
        check("R6 irq_a after clear", {31'h0, irq_a}, 32'h0);

        // R5: clear on the exact clock of a zero event on half B.
        wr(LHI, 2);
        wr(CTB, 1);
        wait_cyc(3);
        rd(RWB, 1, "R1 half B raw");
        wait_cyc(1);
        rd(RWB, 1, "R3 half B sticky");
        wr(RWB, 1);
        rd(RWB, 1, "R5 set wins over clear");
        wr(RWB, 1);
        rd(RWB, 0, "R4 half B clear");
        wr(CTB, 0);

        // R7: mode change wipes everything.
        wr(MOD, 1);
        rd(MOD, 1, "R7 mode stored");
        rd(LHI, 0, "R7 load wiped");
        rd(CHI, 0, "R7 count wiped");
        rd(CTB, 0, "R7 control wiped");
        rd(RWB, 0, "R7 flag wiped");

        // R2: fused counter, carry from low to high.
        wr(LLO, 1);
        wr(LHI, 1);
        wr(CTW, 3);
        wait_cyc(2);
        rd(CLO, 32'hFFFF_FFFF, "R2 low wraps");
        rd(CHI, 0, "R2 high borrows");
        rd(RWW, 0, "R2 no flag on wrap");
        wr(CTW, 2);
        wait_cyc(2);
        rd(CLO, 32'hFFFF_FFFD, "R8 wide holds when stopped");
        wr(LLO, 2);
        rd(CLO, 2, "R2 direct load");
        wr(CTW, 3);
        wait_cyc(2);
        rd(RWW, 0, "R2 flag waits for reload clock");
        wait_cyc(1);
        rd(RWW, 1, "R2 wide flag set");
        rd(CLO, 2, "R2 low reload");
        rd(CHI, 1, "R2 high reload");
        rd(MKW, 1, "R6 wide masked");
        check("R6 irq_wide", {31'h0, irq_wide}, 32'h1);
        check("R8 halves quiet in wide mode", {30'h0, irq_a, irq_b}, 32'h0);

        wr(MOD, 1);
        rd(LLO, 2, "R7 same mode keeps state");
        wr(MOD, 0);
        rd(RWW, 0, "R7 wide flag wiped");
        check("R7 irq_wide wiped", {31'h0, irq_wide}, 32'h0);
        rd(LLO, 0, "R7 load wiped on return");
        rd(MOD, 0, "R7 mode back to 0");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule